// File: doc/BRIEF.md
# Disk Controller Phase Status Tracker

This block follows a floppy-style disk controller through its three phases. In the command phase the host writes command bytes. In the execution phase the controller works and the host waits. In the result phase the host reads result bytes back. The block shows the state of this cycle in a read-only main status byte at I/O offset 3F4. The host reaches the block through a plain register bus that has an address, a read strobe, a write strobe and 8-bit data. The data register sits at the next offset, 3F5.

The block knows the byte counts of a small set of commands. A simplified execution engine beside the block supplies three things: a pulse that marks the end of execution with the results ready, one seek-active flag per drive, and the value of the result byte at the index the block presents. The status byte tells host software when it may touch the data register and in which direction. Accesses that break those rules are dropped.

Top module: `fdc_phase_tracker`

## Requirements
- R1: After synchronous reset the phase output is command (2'b00) and the status byte reads 0x80 with bits 1:0 equal to the drive seek flags. The phase output encodes command as 2'b00, execution as 2'b01 and result as 2'b10.
- R2: The status byte has the following layout. Bit 7 is the request flag, set when the host may use the data register. Bit 6 is the direction flag, 1 meaning the host must read. Bit 4 is command busy. Bits 5, 3 and 2 always read 0. Bits 1:0 copy the seek flags of drive 1 and drive 0 in the same cycle. A read at the status address returns this byte and changes no state. A read at any address other than the status or data address returns 0x00.
- R3: Command busy reads 1 in the cycle after the first command byte is accepted. It stays 1 until the last result byte has been read.
- R4: Seek (low opcode bits 0x0F, 3 bytes), Recalibrate (0x07, 2 bytes) and Specify (0x03, 3 bytes) have no result phase. The cycle after the last byte, command busy is 0, the phase is command and the status reads 0x80 plus the seek bits.
- R5: Sense Drive Status (0x04, 2 bytes) and Sense Interrupt (0x08, 1 byte) enter the execution phase after their last byte. During that phase the status reads 0x10 plus the seek bits, so the request flag is 0.
- R6: A pulse on exec_done during the execution phase moves the block to the result phase on the next cycle, and the status then reads 0xD0 plus the seek bits. A pulse on exec_done in any other phase has no effect.
- R7: Each accepted data read in the result phase returns eng_res_data for the current res_idx. res_idx starts at 0 and steps by one after each read. Sense Drive Status returns 1 byte and Sense Interrupt returns 2. After the last read the block is in the command phase with busy at 0.
- R8: Any other value of the low 5 opcode bits is an invalid command. It takes 1 byte and goes straight to the result phase. Its single result byte reads 0x80, whatever eng_res_data holds.
- R9: The block ignores a data register write while the request flag is 0 or the direction flag is 1. A data register read while the request flag is 0 or the direction flag is 0 returns 0xFF and leaves the state unchanged.
- R10: Decoding uses only opcode bits 4:0. Bits 7:5 of the first byte change neither the byte counts nor the result count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (10) | Host I/O address |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data for the presented address |
| exec_done | input | 1 | Execution finished, results ready |
| seek_active | input | 2 | Per-drive seek in progress |
| eng_res_data | input | 8 | Result byte supplied by the engine for res_idx |
| res_idx | output | 2 | Index of the result byte being presented |
| status_byte | output | 8 | Main status byte |
| phase | output | 2 | Current phase: 00 command, 01 execution, 10 result |

## Verification
The hardest state to reach from the ports is an illegal access made while the phase rules forbid it. Examples are a write during execution, a write in the result phase, and a data read before execution ends. Each of these needs a command accepted to exactly the right byte count first. The stimulus sweeps all 256 first-byte values. For each one it completes the command, tries the forbidden accesses in whatever phase results, and then drains the results. Every byte-count, decode and ignore rule is therefore exercised in every reachable phase.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

    localparam int NUM_DRIVES = 2;
    localparam int CNT_W      = 2;

    localparam logic [4:0] OP_SPECIFY   = 5'h03;
    localparam logic [4:0] OP_SENSE_DRV = 5'h04;
    localparam logic [4:0] OP_RECAL     = 5'h07;
    localparam logic [4:0] OP_SENSE_INT = 5'h08;
    localparam logic [4:0] OP_SEEK      = 5'h0F;

    localparam logic [7:0] INVALID_RESULT = 8'h80;
    localparam logic [7:0] BLOCKED_READ   = 8'hFF;
    localparam logic [7:0] UNMAPPED_READ  = 8'h00;

    typedef enum logic [1:0] {
        PH_CMD  = 2'b00,
        PH_EXEC = 2'b01,
        PH_RES  = 2'b10
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] cmd_len;
        logic [CNT_W-1:0] res_len;
        logic             has_exec;
        logic             invalid;
    } cmd_info_t;

    function automatic cmd_info_t decode_op(input logic [7:0] first);
        cmd_info_t info;
        info = '{cmd_len: 2'd1, res_len: 2'd1, has_exec: 1'b0, invalid: 1'b1};
        case (first[4:0])
            OP_SPECIFY:   info = '{cmd_len: 2'd3, res_len: 2'd0, has_exec: 1'b0, invalid: 1'b0};
            OP_SENSE_DRV: info = '{cmd_len: 2'd2, res_len: 2'd1, has_exec: 1'b1, invalid: 1'b0};
            OP_RECAL:     info = '{cmd_len: 2'd2, res_len: 2'd0, has_exec: 1'b0, invalid: 1'b0};
            OP_SENSE_INT: info = '{cmd_len: 2'd1, res_len: 2'd2, has_exec: 1'b1, invalid: 1'b0};
            OP_SEEK:      info = '{cmd_len: 2'd3, res_len: 2'd0, has_exec: 1'b0, invalid: 1'b0};
            default:      ;
        endcase
        return info;
    endfunction

endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
    import fdc_pkg::*;
(
    input  logic [7:0] first_byte,
    output cmd_info_t  info
);
    always_comb info = decode_op(first_byte);
endmodule

// File: rtl/fdc_phase_fsm.sv
module fdc_phase_fsm
    import fdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_acc,
    input  logic             rd_acc,
    input  logic             exec_done,
    input  cmd_info_t        dec_info,
    output phase_e           phase_q,
    output logic             cmd_busy,
    output logic             invalid_cmd,
    output logic [CNT_W-1:0] res_cnt
);
    logic [CNT_W-1:0] byte_cnt;
    cmd_info_t        info_q;
    cmd_info_t        cur_info;
    logic             last_cmd_byte;
    logic             last_res_byte;

    always_comb begin
        cur_info      = (byte_cnt == '0) ? dec_info : info_q;
        last_cmd_byte = (byte_cnt + 2'd1) == cur_info.cmd_len;
        last_res_byte = res_cnt == (info_q.res_len - 2'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_CMD;
            byte_cnt <= '0;
            res_cnt  <= '0;
            info_q   <= '0;
        end else begin
            case (phase_q)
                PH_CMD: begin
                    if (wr_acc) begin
                        if (byte_cnt == '0) info_q <= dec_info;
                        if (last_cmd_byte) begin
                            byte_cnt <= '0;
                            res_cnt  <= '0;
                            if (cur_info.res_len != '0)
                                phase_q <= cur_info.has_exec ? PH_EXEC : PH_RES;
                        end else begin
                            byte_cnt <= byte_cnt + 2'd1;
                        end
                    end
                end
                PH_EXEC: begin
                    if (exec_done) phase_q <= PH_RES;
                end
                PH_RES: begin
                    if (rd_acc) begin
                        if (last_res_byte) begin
                            phase_q <= PH_CMD;
                            res_cnt <= '0;
                        end else begin
                            res_cnt <= res_cnt + 2'd1;
                        end
                    end
                end
                default: phase_q <= PH_CMD;
            endcase
        end
    end

    assign cmd_busy    = (phase_q != PH_CMD) || (byte_cnt != '0);
    assign invalid_cmd = info_q.invalid;
endmodule

// File: rtl/fdc_status_gen.sv
module fdc_status_gen
    import fdc_pkg::*;
(
    input  phase_e                phase_q,
    input  logic                  cmd_busy,
    input  logic [NUM_DRIVES-1:0] seek_active,
    output logic                  rqm,
    output logic                  dio,
    output logic [7:0]            status
);
    always_comb begin
        rqm    = (phase_q != PH_EXEC);
        dio    = (phase_q == PH_RES);
        status = {rqm, dio, 1'b0, cmd_busy, 2'b00, seek_active};
    end
endmodule

// File: rtl/fdc_phase_tracker.sv
module fdc_phase_tracker
    import fdc_pkg::*;
#(
    parameter int               ADDR_W      = 10,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 10'h3F4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic                  exec_done,
    input  logic [NUM_DRIVES-1:0] seek_active,
    input  logic [7:0]            eng_res_data,
    output logic [CNT_W-1:0]      res_idx,
    output logic [7:0]            status_byte,
    output logic [1:0]            phase
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = STATUS_ADDR + 1'b1;

    cmd_info_t dec_info;
    phase_e    phase_q;
    logic      cmd_busy, invalid_cmd, rqm, dio;
    logic      hit_data, hit_status, wr_acc, rd_acc;
    logic [7:0] res_byte;

    assign hit_data   = (bus_addr == DATA_ADDR);
    assign hit_status = (bus_addr == STATUS_ADDR);
    assign wr_acc     = bus_wr && hit_data && rqm && !dio;
    assign rd_acc     = bus_rd && hit_data && rqm && dio;

    fdc_cmd_decode u_dec (
        .first_byte (bus_wdata),
        .info       (dec_info)
    );

    fdc_phase_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .wr_acc      (wr_acc),
        .rd_acc      (rd_acc),
        .exec_done   (exec_done),
        .dec_info    (dec_info),
        .phase_q     (phase_q),
        .cmd_busy    (cmd_busy),
        .invalid_cmd (invalid_cmd),
        .res_cnt     (res_idx)
    );

    fdc_status_gen u_stat (
        .phase_q     (phase_q),
        .cmd_busy    (cmd_busy),
        .seek_active (seek_active),
        .rqm         (rqm),
        .dio         (dio),
        .status      (status_byte)
    );

    assign res_byte = invalid_cmd ? INVALID_RESULT : eng_res_data;

    always_comb begin
        if (hit_status)     bus_rdata = status_byte;
        else if (hit_data)  bus_rdata = (rqm && dio) ? res_byte : BLOCKED_READ;
        else                bus_rdata = UNMAPPED_READ;
    end

    assign phase = phase_q;
endmodule

// File: rtl/fdc_phase_tracker_chk.sv
module fdc_phase_tracker_chk #(
    parameter int               ADDR_W      = 10,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 10'h3F4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [7:0]        bus_rdata,
    input logic              exec_done,
    input logic [1:0]        seek_active,
    input logic [1:0]        res_idx,
    input logic [7:0]        status_byte,
    input logic [1:0]        phase
);
    localparam logic [ADDR_W-1:0] DATA_A = STATUS_ADDR + 1'b1;

    assert_fixed_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (status_byte[5] == 1'b0) && (status_byte[3:2] == 2'b00));

    assert_drive_bits_R2: assert property (@(posedge clk) disable iff (rst)
        status_byte[1:0] == seek_active);

    assert_first_byte_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'b00 && !status_byte[4] && bus_wr && bus_addr == DATA_A) |=> status_byte[4]);

    assert_exec_status_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'b01) |-> (status_byte[7:6] == 2'b00 && status_byte[4]));

    assert_exec_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'b01 && !exec_done) |=> phase == 2'b01);

    assert_result_status_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'b10) |-> (status_byte[7:6] == 2'b11 && status_byte[4]));

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'b10 && !(bus_rd && bus_addr == DATA_A)) |=> (phase == 2'b10 && $stable(res_idx)));

    assert_blocked_read_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == DATA_A && !status_byte[7]) |-> bus_rdata == 8'hFF);
endmodule

bind fdc_phase_tracker fdc_phase_tracker_chk #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_rdata   (bus_rdata),
    .exec_done   (exec_done),
    .seek_active (seek_active),
    .res_idx     (res_idx),
    .status_byte (status_byte),
    .phase       (phase)
);

// File: tb/fdc_phase_tracker_bench.sv
`timescale 1ns/1ps
module fdc_phase_tracker_bench;
    localparam logic [9:0] ST_A = 10'h3F4;
    localparam logic [9:0] DT_A = 10'h3F5;

    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] bus_addr;
    logic       bus_rd, bus_wr, exec_done;
    logic [7:0] bus_wdata, bus_rdata, eng_res_data, status_byte;
    logic [1:0] seek_active, res_idx, phase;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    fdc_phase_tracker u_fdc_phase_tracker (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .exec_done(exec_done),
        .seek_active(seek_active), .eng_res_data(eng_res_data), .res_idx(res_idx),
        .status_byte(status_byte), .phase(phase)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Bench model of the command table: only op bits 4:0 matter (R10)
    function automatic int m_len(input logic [7:0] op);
        case (op[4:0])
            5'h03, 5'h0F: return 3;
            5'h04, 5'h07: return 2;
            default:      return 1;
        endcase
    endfunction
    function automatic int m_res(input logic [7:0] op);
        case (op[4:0])
            5'h03, 5'h0F, 5'h07: return 0;
            5'h08:               return 2;
            default:             return 1;
        endcase
    endfunction
    function automatic bit m_exec(input logic [7:0] op);
        return (op[4:0] == 5'h04) || (op[4:0] == 5'h08);
    endfunction

    task automatic wr_data(input logic [7:0] b);
        bus_addr = DT_A; bus_wdata = b; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd_data(input logic [7:0] exp, input string tag);
        bus_addr = DT_A; bus_rd = 1'b1;
        #1;
        check(bus_rdata, exp, tag);
        step();
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_addr = ST_A; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
        exec_done = 1'b0; seek_active = 2'b00; eng_res_data = 8'h00;
        repeat (3) step();
        rst = 1'b0;
        step();
        check(status_byte, 8'h80, "R1 reset status");
        check({6'd0, phase}, 8'h00, "R1 reset phase");

        exec_done = 1'b1; step(); exec_done = 1'b0;
        check({6'd0, phase}, 8'h00, "R6 exec_done ignored in idle");
        bus_addr = ST_A; bus_rd = 1'b1; #1;
        check(bus_rdata, 8'h80, "R2 status read");
        step(); bus_rd = 1'b0;
        check(status_byte, 8'h80, "R2 status read leaves state");
        bus_addr = 10'h3F0; #1;
        check(bus_rdata, 8'h00, "R2 unmapped read");
        rd_data(8'hFF, "R9 data read in command phase");
        check(status_byte, 8'h80, "R9 blocked read leaves state");

        for (int op = 0; op < 256; op++) begin
            logic [7:0] o;
            logic [7:0] s;
            int len, nres;
            bit ex, inv;
            o = 8'(op);
            seek_active = o[1:0] ^ o[6:5];
            s = {6'd0, seek_active};
            len = m_len(o); nres = m_res(o); ex = m_exec(o);
            inv = (nres != 0) && !ex;
            step();
            check(status_byte, 8'h80 | s, "R2 idle status with seek bits");
            for (int i = 0; i < len; i++) begin
                wr_data((i == 0) ? o : 8'(8'h40 + i));
                if (i < len - 1)
                    check(status_byte, 8'h90 | s, "R3 busy between command bytes");
            end
            if (nres == 0) begin
                check(status_byte, 8'h80 | s, "R4 no-result command clears busy");
                check({6'd0, phase}, 8'h00, "R4 phase back to command");
            end else begin
                if (ex) begin
                    check(status_byte, 8'h10 | s, "R5 execution status");
                    check({6'd0, phase}, 8'h01, "R5 execution phase");
                    wr_data(8'h55);
                    check(status_byte, 8'h10 | s, "R9 write during execution ignored");
                    rd_data(8'hFF, "R9 read during execution");
                    check({6'd0, phase}, 8'h01, "R9 read during execution leaves phase");
                    exec_done = 1'b1; step(); exec_done = 1'b0;
                end
                check(status_byte, 8'hD0 | s, inv ? "R8 invalid goes to result" : "R6 result status");
                check({6'd0, phase}, 8'h02, "R6 result phase");
                wr_data(8'hAA);
                check(status_byte, 8'hD0 | s, "R9 write in result phase ignored");
                for (int k = 0; k < nres; k++) begin
                    eng_res_data = o ^ 8'(k * 37 + 5);
                    check({6'd0, res_idx}, 8'(k), "R7 result index");
                    rd_data(inv ? 8'h80 : (o ^ 8'(k * 37 + 5)), inv ? "R8 invalid result byte" : "R7 result byte");
                    if (k < nres - 1)
                        check(status_byte, 8'hD0 | s, "R7 still in result phase");
                end
                check(status_byte, 8'h80 | s, "R7 idle after last result (R3 busy falls)");
                check({6'd0, phase}, 8'h00, "R7 phase back to command");
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule